// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the running memory address and the row and column counters of one DMA channel. A start strobe loads the start address and the two counts and puts the channel into the running state. From then on, every element the transfer engine reports as accepted moves the address by a signed column stride and takes one off the column count. When the last element of a row has been accepted, the block can raise a one-cycle interrupt pulse. It then does one of three things: it opens the next row (two-dimensional mode), it asks for the next descriptor and reloads itself from its inputs, or it stops the channel and flags completion.

The bus protocol and the descriptor fetch are outside the block. The surrounding channel logic presents the next descriptor's start address and counts on the inputs before a reload takes effect. The block checks the configuration when the channel starts. The stride magnitude must equal the element size and the start address must be aligned to it. A configuration that fails either check raises the error flag and the channel does not start.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, running, done, error, irqPulse and reloadReq are 0 and the current address and both current counts are 0.
- R2: startPulse with a legal configuration sets running and clears done and error. At the next clock edge the current address takes startAddr and the current counts take xCount and yCount.
- R3: A count input of 0 loads the matching current count as all ones (the maximum count).
- R4: While running, each elemAccept that does not end a row adds xMod, taken as two's complement and sign-extended, to the current address and lowers the current column count by one.
- R5: Accepting an element while the current column count is 1 ends the row. When cfgIrqEn is 1, irqPulse is high for exactly the following cycle. When cfgIrqEn is 0, irqPulse stays low.
- R6: A row end with cfgEn2d = 1 and a current row count above 1 lowers the row count by one and reloads the column count from xCount. It sets the address to the address before that element, plus xMod, minus xMod, plus yMod. The channel keeps running.
- R7: A row end with no further row and cfgFlow = 0 (stop) clears running and sets done. The address still advances by xMod and the column count reaches 0.
- R8: A row end with no further row and cfgFlow not 0 pulses reloadReq for one cycle. The current address and counts reload from startAddr, xCount and yCount as presented at that edge, and running stays set.
- R9: Element size is 1 << cfgElemSize bytes, and cfgElemSize = 3 is illegal. If the size is illegal, or |xMod| is not the element size, or startAddr is not a multiple of it, startPulse sets error, leaves running clear and loads nothing.
- R10: elemAccept while running is clear leaves the current address and counts unchanged.
- R11: With cfgEn2d = 0 the row count is not consulted, so the first row end takes the flow action (R7/R8) whatever yCount holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Check the configuration and load a new job |
| elemAccept | input | 1 | One element transferred this cycle |
| cfgEn2d | input | 1 | Two-dimensional mode enable |
| cfgIrqEn | input | 1 | Interrupt at each row end |
| cfgFlow | input | 2 | 0 stops at the end, any other value reloads |
| cfgElemSize | input | 2 | log2 of the element size in bytes, 0 to 2 |
| startAddr | input | ADDR_W | Start address of the job or next descriptor |
| xCount | input | CNT_W | Elements per row, 0 meaning the maximum |
| yCount | input | CNT_W | Rows, 0 meaning the maximum |
| xMod | input | MOD_W | Signed column stride in bytes |
| yMod | input | MOD_W | Signed row stride in bytes |
| curAddr | output | ADDR_W | Current address |
| curXCount | output | CNT_W | Elements left in the row |
| curYCount | output | CNT_W | Rows left |
| running | output | 1 | Channel active |
| done | output | 1 | Job completed in stop mode |
| error | output | 1 | Configuration rejected |
| irqPulse | output | 1 | One-cycle row-end interrupt |
| reloadReq | output | 1 | One-cycle descriptor reload request |

## Verification
The hardest case to reach from the ports is a descriptor reload whose new values differ from the old ones. It needs a row end in a non-stop flow with the next descriptor already on the inputs. The stimulus changes startAddr and xCount between the second-last and the last element, so the reloaded values can be told apart from the initial load. The two-dimensional row wrap is reached with a short row and a two-row job. That test also checks the address arithmetic and that the interrupt stays quiet when it is disabled.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  // Strobes from control to datapath, at most one acted on per cycle.
  typedef struct packed {
    logic load;    // take a new job from the inputs
    logic step;    // advance by one element within a row
    logic wrap;    // open the next row
    logic reload;  // take the next descriptor from the inputs
  } dpStrobe_t;

endpackage

// File: rtl/dma2d_datapath.sv
module dma2d_datapath
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xCount,
  input  logic [CNT_W-1:0]  yCount,
  input  logic [MOD_W-1:0]  xMod,
  input  logic [MOD_W-1:0]  yMod,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  curXCount,
  output logic [CNT_W-1:0]  curYCount,
  output logic              lastX,
  output logic              moreRows
);

  localparam int EXT_W = ADDR_W - MOD_W;

  logic [ADDR_W-1:0] xModExt;
  logic [ADDR_W-1:0] yModExt;
  logic [ADDR_W-1:0] stepAddr;
  logic [ADDR_W-1:0] wrapAddr;
  logic [CNT_W-1:0]  loadX;
  logic [CNT_W-1:0]  loadY;

  // Sign extension of the strides; a narrower address simply truncates.
  generate
    if (EXT_W > 0) begin : g_ext
      assign xModExt = {{EXT_W{xMod[MOD_W-1]}}, xMod};
      assign yModExt = {{EXT_W{yMod[MOD_W-1]}}, yMod};
    end else begin : g_trunc
      assign xModExt = xMod[ADDR_W-1:0];
      assign yModExt = yMod[ADDR_W-1:0];
    end
  endgenerate

  // The wrap undoes the column step of the row's last element and applies the row stride.
  assign stepAddr = curAddr + xModExt;
  assign wrapAddr = stepAddr - xModExt + yModExt;

  assign loadX = (xCount == '0) ? '1 : xCount;
  assign loadY = (yCount == '0) ? '1 : yCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curXCount <= '0;
      curYCount <= '0;
    end else if (strobe.load || strobe.reload) begin
      curAddr   <= startAddr;
      curXCount <= loadX;
      curYCount <= loadY;
    end else if (strobe.wrap) begin
      curAddr   <= wrapAddr;
      curXCount <= loadX;
      curYCount <= curYCount - 1'b1;
    end else if (strobe.step) begin
      curAddr   <= stepAddr;
      curXCount <= curXCount - 1'b1;
    end
  end

  assign lastX    = (curXCount == CNT_W'(1));
  assign moreRows = (curYCount > CNT_W'(1));

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
#(
  parameter int MOD_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             elemAccept,
  input  logic             cfgEn2d,
  input  logic             cfgIrqEn,
  input  logic [1:0]       cfgFlow,
  input  logic [1:0]       cfgElemSize,
  input  logic [1:0]       startLow,
  input  logic [MOD_W-1:0] xMod,
  input  logic             lastX,
  input  logic             moreRows,
  output dpStrobe_t        strobe,
  output logic             running,
  output logic             done,
  output logic             error,
  output logic             irqPulse,
  output logic             reloadReq
);

  localparam logic [1:0] FLOW_STOP = 2'd0;

  logic [MOD_W-1:0] absMod;
  logic [MOD_W-1:0] elemBytes;
  logic [1:0]       alignMask;
  logic             sizeLegal;
  logic             cfgOk;
  logic             accepted;
  logic             rowEnd;
  logic             wrapNow;
  logic             reloadNow;
  logic             finishNow;

  assign absMod    = xMod[MOD_W-1] ? (~xMod + 1'b1) : xMod;
  assign elemBytes = MOD_W'(1) << cfgElemSize;
  assign sizeLegal = (cfgElemSize != 2'd3);

  always_comb begin
    case (cfgElemSize)
      2'd0:    alignMask = 2'b00;
      2'd1:    alignMask = 2'b01;
      default: alignMask = 2'b11;
    endcase
  end

  assign cfgOk = sizeLegal && (absMod == elemBytes) && ((startLow & alignMask) == 2'b00);

  // A start in the same cycle takes precedence over an element strobe.
  assign accepted  = elemAccept && running && !startPulse;
  assign rowEnd    = accepted && lastX;
  assign wrapNow   = rowEnd && cfgEn2d && moreRows;
  assign reloadNow = rowEnd && !wrapNow && (cfgFlow != FLOW_STOP);
  assign finishNow = rowEnd && !wrapNow && (cfgFlow == FLOW_STOP);

  always_comb begin
    strobe        = '0;
    strobe.load   = startPulse && cfgOk;
    strobe.wrap   = wrapNow;
    strobe.reload = reloadNow;
    strobe.step   = accepted && !wrapNow && !reloadNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      irqPulse  <= 1'b0;
      reloadReq <= 1'b0;
    end else begin
      irqPulse  <= rowEnd && cfgIrqEn;
      reloadReq <= reloadNow;
      if (startPulse) begin
        running <= cfgOk;
        done    <= 1'b0;
        error   <= !cfgOk;
      end else if (finishNow) begin
        running <= 1'b0;
        done    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              elemAccept,
  input  logic              cfgEn2d,
  input  logic              cfgIrqEn,
  input  logic [1:0]        cfgFlow,
  input  logic [1:0]        cfgElemSize,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  xCount,
  input  logic [CNT_W-1:0]  yCount,
  input  logic [MOD_W-1:0]  xMod,
  input  logic [MOD_W-1:0]  yMod,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  curXCount,
  output logic [CNT_W-1:0]  curYCount,
  output logic              running,
  output logic              done,
  output logic              error,
  output logic              irqPulse,
  output logic              reloadReq
);

  dpStrobe_t strobe;
  logic      lastX;
  logic      moreRows;

  dma2d_ctrl #(.MOD_W(MOD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .elemAccept (elemAccept),
    .cfgEn2d    (cfgEn2d),
    .cfgIrqEn   (cfgIrqEn),
    .cfgFlow    (cfgFlow),
    .cfgElemSize(cfgElemSize),
    .startLow   (startAddr[1:0]),
    .xMod       (xMod),
    .lastX      (lastX),
    .moreRows   (moreRows),
    .strobe     (strobe),
    .running    (running),
    .done       (done),
    .error      (error),
    .irqPulse   (irqPulse),
    .reloadReq  (reloadReq)
  );

  dma2d_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startAddr(startAddr),
    .xCount   (xCount),
    .yCount   (yCount),
    .xMod     (xMod),
    .yMod     (yMod),
    .curAddr  (curAddr),
    .curXCount(curXCount),
    .curYCount(curYCount),
    .lastX    (lastX),
    .moreRows (moreRows)
  );

endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MOD_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              elemAccept,
  input logic              cfgEn2d,
  input logic              cfgIrqEn,
  input logic [MOD_W-1:0]  xMod,
  input logic [MOD_W-1:0]  yMod,
  input logic [ADDR_W-1:0] curAddr,
  input logic [CNT_W-1:0]  curXCount,
  input logic [CNT_W-1:0]  curYCount,
  input logic              running,
  input logic              done,
  input logic              error,
  input logic              irqPulse,
  input logic              reloadReq
);

  logic [ADDR_W-1:0] xExt;
  logic [ADDR_W-1:0] yExt;
  logic              midRow;
  logic              rowWrap;

  assign xExt    = ADDR_W'($signed(xMod));
  assign yExt    = ADDR_W'($signed(yMod));
  assign midRow  = running && elemAccept && !startPulse && (curXCount > CNT_W'(1));
  assign rowWrap = running && elemAccept && !startPulse && (curXCount == CNT_W'(1))
                   && cfgEn2d && (curYCount > CNT_W'(1));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    midRow |=> (curAddr == $past(curAddr) + $past(xExt)) && (curXCount == $past(curXCount) - 1'b1));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    rowWrap |=> (curYCount == $past(curYCount) - 1'b1) && (curAddr == $past(curAddr) + $past(yExt)) && running);

  assert_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(cfgIrqEn && running && elemAccept && (curXCount == CNT_W'(1))));

  assert_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !running && (curXCount == '0));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    reloadReq |-> running);

  assert_error_R9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !running);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startPulse) |=> $stable(curAddr) && $stable(curXCount) && $stable(curYCount));

endmodule

bind dma2d_addr_gen dma2d_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .elemAccept(elemAccept),
  .cfgEn2d   (cfgEn2d),
  .cfgIrqEn  (cfgIrqEn),
  .xMod      (xMod),
  .yMod      (yMod),
  .curAddr   (curAddr),
  .curXCount (curXCount),
  .curYCount (curYCount),
  .running   (running),
  .done      (done),
  .error     (error),
  .irqPulse  (irqPulse),
  .reloadReq (reloadReq)
);

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        elemAccept = 1'b0;
  logic        cfgEn2d = 1'b0;
  logic        cfgIrqEn = 1'b0;
  logic [1:0]  cfgFlow = 2'd0;
  logic [1:0]  cfgElemSize = 2'd0;
  logic [31:0] startAddr = '0;
  logic [15:0] xCount = '0;
  logic [15:0] yCount = '0;
  logic [15:0] xMod = '0;
  logic [15:0] yMod = '0;
  logic [31:0] curAddr;
  logic [15:0] curXCount;
  logic [15:0] curYCount;
  logic        running, done, error, irqPulse, reloadReq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma2d_addr_gen dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .elemAccept(elemAccept),
    .cfgEn2d(cfgEn2d), .cfgIrqEn(cfgIrqEn), .cfgFlow(cfgFlow), .cfgElemSize(cfgElemSize),
    .startAddr(startAddr), .xCount(xCount), .yCount(yCount), .xMod(xMod), .yMod(yMod),
    .curAddr(curAddr), .curXCount(curXCount), .curYCount(curYCount), .running(running),
    .done(done), .error(error), .irqPulse(irqPulse), .reloadReq(reloadReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] addr, input logic [15:0] xc, input logic [15:0] yc,
                       input logic [15:0] xm, input logic [15:0] ym, input logic [1:0] sz,
                       input logic en2, input logic irq, input logic [1:0] flow);
    startAddr = addr; xCount = xc; yCount = yc; xMod = xm; yMod = ym;
    cfgElemSize = sz; cfgEn2d = en2; cfgIrqEn = irq; cfgFlow = flow;
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic acceptOne();
    @(negedge clk) elemAccept = 1'b1;
    @(negedge clk) elemAccept = 1'b0;
  endtask

  task automatic testReset();
    check("R1 running", 32'(running), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 error", 32'(error), 32'd0);
    check("R1 irqPulse", 32'(irqPulse), 32'd0);
    check("R1 reloadReq", 32'(reloadReq), 32'd0);
    check("R1 curAddr", curAddr, 32'd0);
    check("R1 curXCount", 32'(curXCount), 32'd0);
  endtask

  task automatic testStop1d();
    setup(32'h1000, 16'd3, 16'd1, 16'd4, 16'd0, 2'd2, 1'b0, 1'b1, 2'd0);
    pulseStart();
    check("R2 running", 32'(running), 32'd1);
    check("R2 curAddr", curAddr, 32'h1000);
    check("R2 curXCount", 32'(curXCount), 32'd3);
    check("R2 curYCount", 32'(curYCount), 32'd1);
    acceptOne();
    check("R4 addr step", curAddr, 32'h1004);
    check("R4 x dec", 32'(curXCount), 32'd2);
    check("R5 no irq mid-row", 32'(irqPulse), 32'd0);
    acceptOne();
    acceptOne();
    check("R7 final addr", curAddr, 32'h100C);
    check("R7 x zero", 32'(curXCount), 32'd0);
    check("R7 done", 32'(done), 32'd1);
    check("R7 stopped", 32'(running), 32'd0);
    check("R5 irq high", 32'(irqPulse), 32'd1);
    @(negedge clk);
    check("R5 irq one cycle", 32'(irqPulse), 32'd0);
    // R10: strobes after completion leave state alone
    acceptOne();
    acceptOne();
    check("R10 addr held", curAddr, 32'h100C);
    check("R10 x held", 32'(curXCount), 32'd0);
    check("R10 done held", 32'(done), 32'd1);
  endtask

  task automatic testNegStride();
    setup(32'h2000, 16'd2, 16'd1, 16'hFFFE, 16'd0, 2'd1, 1'b0, 1'b0, 2'd0);
    pulseStart();
    check("R2 done cleared", 32'(done), 32'd0);
    acceptOne();
    check("R4 negative stride", curAddr, 32'h1FFE);
    acceptOne();
    check("R7 negative end addr", curAddr, 32'h1FFC);
    check("R5 irq disabled", 32'(irqPulse), 32'd0);
  endtask

  task automatic testWrap2d();
    setup(32'h100, 16'd2, 16'd2, 16'd1, 16'd5, 2'd0, 1'b1, 1'b0, 2'd0);
    pulseStart();
    acceptOne();
    check("R4 2d step", curAddr, 32'h101);
    acceptOne();
    check("R6 wrap addr", curAddr, 32'h106);
    check("R6 x reload", 32'(curXCount), 32'd2);
    check("R6 y dec", 32'(curYCount), 32'd1);
    check("R6 still running", 32'(running), 32'd1);
    check("R5 no irq when disabled", 32'(irqPulse), 32'd0);
    acceptOne();
    acceptOne();
    check("R7 2d done", 32'(done), 32'd1);
    check("R7 2d end addr", curAddr, 32'h108);
  endtask

  task automatic testReload();
    setup(32'h40, 16'd2, 16'd1, 16'd1, 16'd0, 2'd0, 1'b0, 1'b0, 2'd1);
    pulseStart();
    acceptOne();
    startAddr = 32'h80; xCount = 16'd1; yCount = 16'd4;
    acceptOne();
    check("R8 reloadReq", 32'(reloadReq), 32'd1);
    check("R8 addr reload", curAddr, 32'h80);
    check("R8 x reload", 32'(curXCount), 32'd1);
    check("R8 y reload", 32'(curYCount), 32'd4);
    check("R8 running", 32'(running), 32'd1);
    check("R8 no done", 32'(done), 32'd0);
    @(negedge clk);
    check("R8 reloadReq one cycle", 32'(reloadReq), 32'd0);
  endtask

  task automatic testZeroCount();
    setup(32'h0, 16'd0, 16'd0, 16'd1, 16'd0, 2'd0, 1'b1, 1'b0, 2'd0);
    pulseStart();
    check("R3 x max", 32'(curXCount), 32'h0000FFFF);
    check("R3 y max", 32'(curYCount), 32'h0000FFFF);
  endtask

  task automatic testIgnoreY();
    setup(32'h300, 16'd1, 16'd3, 16'd1, 16'd8, 2'd0, 1'b0, 1'b0, 2'd0);
    pulseStart();
    acceptOne();
    check("R11 done in 1d", 32'(done), 32'd1);
    check("R11 addr in 1d", curAddr, 32'h301);
  endtask

  task automatic testErrors();
    setup(32'h500, 16'd4, 16'd1, 16'd2, 16'd0, 2'd2, 1'b0, 1'b0, 2'd0);
    pulseStart();
    check("R9 stride mismatch error", 32'(error), 32'd1);
    check("R9 stride mismatch not running", 32'(running), 32'd0);
    check("R9 nothing loaded", curAddr, 32'h301);
    setup(32'h501, 16'd4, 16'd1, 16'd2, 16'd0, 2'd1, 1'b0, 1'b0, 2'd0);
    pulseStart();
    check("R9 misaligned error", 32'(error), 32'd1);
    setup(32'h500, 16'd4, 16'd1, 16'd8, 16'd0, 2'd3, 1'b0, 1'b0, 2'd0);
    pulseStart();
    check("R9 illegal size error", 32'(error), 32'd1);
    acceptOne();
    check("R10 ignored after error", curAddr, 32'h301);
    setup(32'h500, 16'd4, 16'd1, 16'hFFFC, 16'd0, 2'd2, 1'b0, 1'b0, 2'd0);
    pulseStart();
    check("R2 error cleared", 32'(error), 32'd0);
    check("R2 running after error", 32'(running), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testStop1d();
    testNegStride();
    testWrap2d();
    testReload();
    testZeroCount();
    testIgnoreY();
    testErrors();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule